// File: doc/BRIEF.md
# Single-Wire Keypad Poll Controller

This block is the host end of a one-wire keypad link. The remote end holds a row and column scanner. Its stepping clock is the host driving the shared line low, and it answers by pulling the line down. Once per polling interval the controller sends a burst of pulses. Each pulse period has three phases: a drive-low phase, a drive-high phase and a released phase. The controller samples the line at the end of the released phase. A low sample means the remote end is sinking current, either through a pressed key or through its end-of-keypad marker.

The remote scan is not locked to the burst, so the controller has no fixed frame position. Whenever it sees a run of five low samples, it takes the next sample as the first position of a new scan. The next twenty samples form four rows of five positions each. Position 0 of each row carries no key. In a row that holds a pressed key, every position is low except the one for that key's column. One scan lasts thirty pulses, so a sixty-pulse burst reads the keypad twice. A key code is reported only when both reads agree.

Top module: `kp_poll_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, idle is 1, line_drv_lo is 1, line_drv_hi is 0, key_valid is 0 and key_code is 0.
- R2: Between bursts, idle is 1 and line_drv_lo is held on for exactly GAP_CYC cycles.
- R3: Each pulse period has three phases in this order: LO_CYC cycles with line_drv_lo on, HI_CYC cycles with line_drv_hi on, and SAMP_CYC cycles with both enables off. The two enables are never on together. The line is sampled once, at the end of the released phase, through a two-stage synchronizer.
- R4: Every burst has exactly PULSES pulse periods, whatever the line does.
- R5: Five consecutive low samples form the end-of-keypad marker, and the next sample is row 0, position 0. A fresh run of five lows restarts alignment at any point, including in the middle of a scan.
- R6: The 20 samples after the marker are rows 0 to 3, each with positions 0 to 4. A row sampled all high has no key. A row sampled high at exactly one position p, where p is 1 to 4, and low everywhere else holds a key in column p. Any other row pattern makes the scan invalid.
- R7: A scan yields a key only if exactly one row holds a key and no row is invalid. Its code is row*4 + (column-1). The rows are 1 2 3 A, 4 5 6 B, 7 8 9 C and * 0 # D, so for example '1'=0, '5'=5, '9'=10, '0'=13, '#'=14, 'D'=15 and 'A'=3.
- R8: After the last sample of a burst, if the final two scans completed in that burst both yield the same key, key_valid is 1 for exactly one clock, during the gap, and key_code takes that key's code.
- R9: In every other case, such as no key, two keys, or two scans that disagree, key_valid stays 0 for the burst and key_code keeps its previous value.
- R10: A burst in which fewer than two scans complete produces no report. This happens after the remote phase jumps and alignment is regained partway through the burst. A scan that straddles a gap is counted in the burst where it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled state of the shared line (1 = high) |
| line_drv_lo | output | 1 | Enable for pulling the line low |
| line_drv_hi | output | 1 | Enable for driving the line high |
| key_valid | output | 1 | One-cycle strobe for a confirmed key |
| key_code | output | $clog2(ROWS)+$clog2(COLS) | Code of the last confirmed key |
| idle | output | 1 | High during the gap between bursts |

## Verification
The only outputs of the decode path are the strobe and the code, and both change only in the gap after a burst. A slipped column or row counter therefore first shows up as a wrong code, or as a missing strobe, two to three cycles after idle rises at the end of the burst in which it happened. A fault in the marker detector shows one burst later, as a missed report after a phase jump or a false report from a scan that straddles a gap. Faults in the pulse sequencer are visible within one burst as a wrong count of drive-high pulses or a wrong gap length.

// File: rtl/kp_pkg.sv
`timescale 1ns/1ps
package kp_pkg;

  typedef enum logic [1:0] {
    PH_GAP = 2'd0,
    PH_LO  = 2'd1,
    PH_HI  = 2'd2,
    PH_REL = 2'd3
  } phase_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/kp_pulse_gen.sv
`timescale 1ns/1ps
module kp_pulse_gen
  import kp_pkg::*;
#(
  parameter int LO_CYC      = 400,
  parameter int HI_CYC      = 550,
  parameter int SAMP_CYC    = 450,
  parameter int GAP_CYC     = 2250000,
  parameter int PULSES      = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic drv_lo,
  output logic drv_hi,
  output logic idle,
  output logic smp_valid,
  output logic smp_bit,
  output logic smp_last
);

  localparam int CNT_W = $clog2(max_of4(LO_CYC, HI_CYC, SAMP_CYC, GAP_CYC) + 1);
  localparam int PCW   = $clog2(PULSES + 1);

  phase_t                 ph;
  logic [CNT_W-1:0]       cnt;
  logic [PCW-1:0]         pcnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end
  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_GAP;
      cnt       <= '0;
      pcnt      <= '0;
      smp_valid <= 1'b0;
      smp_bit   <= 1'b0;
      smp_last  <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      smp_last  <= 1'b0;
      case (ph)
        PH_GAP: begin
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            cnt  <= '0;
            pcnt <= '0;
            ph   <= PH_LO;
          end else cnt <= cnt + 1'b1;
        end
        PH_LO: begin
          if (cnt == CNT_W'(LO_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_HI;
          end else cnt <= cnt + 1'b1;
        end
        PH_HI: begin
          if (cnt == CNT_W'(HI_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_REL;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CNT_W'(SAMP_CYC - 1)) begin
            cnt       <= '0;
            smp_valid <= 1'b1;
            smp_bit   <= line_s;
            if (pcnt == PCW'(PULSES - 1)) begin
              smp_last <= 1'b1;
              ph       <= PH_GAP;
            end else begin
              pcnt <= pcnt + 1'b1;
              ph   <= PH_LO;
            end
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign drv_lo = (ph == PH_GAP) || (ph == PH_LO);
  assign drv_hi = (ph == PH_HI);
  assign idle   = (ph == PH_GAP);

  // R3: the enables never overlap
  a_r3_drive_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(drv_lo && drv_hi));
  // R3: the high phase is entered only from the low phase
  a_r3_high_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_hi) |-> $past(drv_lo));
  // R3: a sample is taken only on leaving the released phase
  a_r3_sample_at_release: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ($past(ph) == PH_REL));
  // R4: the pulse index stays inside the burst
  a_r4_pulse_bound: assert property (@(posedge clk) disable iff (rst)
    pcnt < PCW'(PULSES));
  // R2: the last sample of a burst leads straight into the gap
  a_r2_last_enters_gap: assert property (@(posedge clk) disable iff (rst)
    smp_last |-> idle);

endmodule

// File: rtl/kp_scan_decode.sv
`timescale 1ns/1ps
module kp_scan_decode #(
  parameter int MARK_LEN = 5,
  parameter int ROWS     = 4,
  parameter int COLS     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic smp_bit,
  input  logic smp_last,
  output logic scan_done,
  output logic scan_ok,
  output logic [$clog2(ROWS)+$clog2(COLS)-1:0] scan_code,
  output logic burst_done
);

  localparam int SLOTS  = COLS + 1;
  localparam int COL_W  = $clog2(SLOTS);
  localparam int HC_W   = $clog2(SLOTS + 1);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COLB_W = $clog2(COLS);
  localparam int RUN_W  = $clog2(MARK_LEN + 1);
  localparam int CODE_W = ROW_W + COLB_W;

  logic [RUN_W-1:0]  run;
  logic              active;
  logic [COL_W-1:0]  col_i, hi_col, hi_col_n;
  logic [ROW_W-1:0]  row_i;
  logic [HC_W-1:0]   hi_cnt, hi_cnt_n;
  logic [1:0]        key_cnt, key_cnt_n;
  logic              bad, bad_n;
  logic [CODE_W-1:0] code_acc, code_n;
  logic [COLB_W-1:0] col_code;
  logic              marker, row_end, scan_end, row_blank, row_key, row_bad;

  always_comb begin
    marker    = smp_valid && !smp_bit && (run == RUN_W'(MARK_LEN - 1));
    hi_cnt_n  = hi_cnt + HC_W'(smp_bit);
    hi_col_n  = smp_bit ? col_i : hi_col;
    row_end   = (col_i == COL_W'(SLOTS - 1));
    scan_end  = row_end && (row_i == ROW_W'(ROWS - 1));
    row_blank = (hi_cnt_n == HC_W'(SLOTS));
    row_key   = (hi_cnt_n == HC_W'(1)) && (hi_col_n != '0);
    row_bad   = !row_blank && !row_key;
    col_code  = COLB_W'(hi_col_n - 1'b1);
    key_cnt_n = (row_key && key_cnt != 2'd2) ? key_cnt + 2'd1 : key_cnt;
    bad_n     = bad || row_bad || (row_key && key_cnt != 2'd0);
    code_n    = row_key ? {row_i, col_code} : code_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= '0;
      active     <= 1'b0;
      col_i      <= '0;
      row_i      <= '0;
      hi_cnt     <= '0;
      hi_col     <= '0;
      key_cnt    <= '0;
      bad        <= 1'b0;
      code_acc   <= '0;
      scan_done  <= 1'b0;
      scan_ok    <= 1'b0;
      scan_code  <= '0;
      burst_done <= 1'b0;
    end else begin
      scan_done  <= 1'b0;
      burst_done <= smp_valid && smp_last;
      if (smp_valid) begin
        if (smp_bit)                          run <= '0;
        else if (run != RUN_W'(MARK_LEN))     run <= run + 1'b1;
        if (marker) begin
          active   <= 1'b1;
          col_i    <= '0;
          row_i    <= '0;
          hi_cnt   <= '0;
          hi_col   <= '0;
          key_cnt  <= '0;
          bad      <= 1'b0;
          code_acc <= '0;
        end else if (active) begin
          if (row_end) begin
            col_i    <= '0;
            hi_cnt   <= '0;
            hi_col   <= '0;
            key_cnt  <= key_cnt_n;
            bad      <= bad_n;
            code_acc <= code_n;
            if (scan_end) begin
              active    <= 1'b0;
              scan_done <= 1'b1;
              scan_ok   <= !bad_n && (key_cnt_n == 2'd1);
              scan_code <= code_n;
            end else begin
              row_i <= row_i + 1'b1;
            end
          end else begin
            col_i  <= col_i + 1'b1;
            hi_cnt <= hi_cnt_n;
            hi_col <= hi_col_n;
          end
        end
      end
    end
  end

  // R5: a marker sample realigns to row 0, position 0
  a_r5_marker_realigns: assert property (@(posedge clk) disable iff (rst)
    marker |=> (active && col_i == '0 && row_i == '0));
  // R6: the position index stays inside a row
  a_r6_col_bound: assert property (@(posedge clk) disable iff (rst)
    col_i < COL_W'(SLOTS));
  // R7: a scan result appears only when a sample was consumed
  a_r7_done_after_sample: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> $past(smp_valid));

endmodule

// File: rtl/kp_vote.sv
`timescale 1ns/1ps
module kp_vote #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_done,
  input  logic              scan_ok,
  input  logic [CODE_W-1:0] scan_code,
  input  logic              burst_done,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code
);

  logic [1:0]        n_seen, n_seen_n;
  logic              old_ok, new_ok, old_ok_n, new_ok_n;
  logic [CODE_W-1:0] old_code, new_code, old_code_n, new_code_n;
  logic              agree;

  always_comb begin
    n_seen_n   = n_seen;
    old_ok_n   = old_ok;
    old_code_n = old_code;
    new_ok_n   = new_ok;
    new_code_n = new_code;
    if (scan_done) begin
      old_ok_n   = new_ok;
      old_code_n = new_code;
      new_ok_n   = scan_ok;
      new_code_n = scan_code;
      if (n_seen != 2'd2) n_seen_n = n_seen + 2'd1;
    end
    agree = (n_seen_n == 2'd2) && old_ok_n && new_ok_n && (old_code_n == new_code_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_seen    <= '0;
      old_ok    <= 1'b0;
      new_ok    <= 1'b0;
      old_code  <= '0;
      new_code  <= '0;
      key_valid <= 1'b0;
      key_code  <= '0;
    end else begin
      key_valid <= 1'b0;
      old_ok    <= old_ok_n;
      old_code  <= old_code_n;
      new_ok    <= new_ok_n;
      new_code  <= new_code_n;
      if (burst_done) begin
        n_seen    <= '0;
        key_valid <= agree;
        if (agree) key_code <= new_code_n;
      end else begin
        n_seen <= n_seen_n;
      end
    end
  end

  // R8: the strobe lasts one cycle
  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);
  // R8: the strobe follows the end of a burst
  a_r8_strobe_after_burst: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $past(burst_done));
  // R9: the code moves only together with the strobe
  a_r9_code_holds: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> $stable(key_code));

endmodule

// File: rtl/kp_poll_ctrl.sv
`timescale 1ns/1ps
module kp_poll_ctrl #(
  parameter int LO_CYC      = 400,
  parameter int HI_CYC      = 550,
  parameter int SAMP_CYC    = 450,
  parameter int GAP_CYC     = 2250000,
  parameter int PULSES      = 60,
  parameter int SYNC_STAGES = 2,
  parameter int MARK_LEN    = 5,
  parameter int ROWS        = 4,
  parameter int COLS        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_drv_lo,
  output logic line_drv_hi,
  output logic key_valid,
  output logic [$clog2(ROWS)+$clog2(COLS)-1:0] key_code,
  output logic idle
);

  localparam int CODE_W = $clog2(ROWS) + $clog2(COLS);

  logic              smp_valid, smp_bit, smp_last;
  logic              scan_done, scan_ok, burst_done;
  logic [CODE_W-1:0] scan_code;

  kp_pulse_gen #(
    .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .SAMP_CYC(SAMP_CYC),
    .GAP_CYC(GAP_CYC), .PULSES(PULSES), .SYNC_STAGES(SYNC_STAGES)
  ) u_gen (
    .clk(clk), .rst(rst), .line_in(line_in),
    .drv_lo(line_drv_lo), .drv_hi(line_drv_hi), .idle(idle),
    .smp_valid(smp_valid), .smp_bit(smp_bit), .smp_last(smp_last)
  );

  kp_scan_decode #(
    .MARK_LEN(MARK_LEN), .ROWS(ROWS), .COLS(COLS)
  ) u_dec (
    .clk(clk), .rst(rst),
    .smp_valid(smp_valid), .smp_bit(smp_bit), .smp_last(smp_last),
    .scan_done(scan_done), .scan_ok(scan_ok), .scan_code(scan_code),
    .burst_done(burst_done)
  );

  kp_vote #(
    .CODE_W(CODE_W)
  ) u_vote (
    .clk(clk), .rst(rst),
    .scan_done(scan_done), .scan_ok(scan_ok), .scan_code(scan_code),
    .burst_done(burst_done),
    .key_valid(key_valid), .key_code(key_code)
  );

  // R8: a confirmed key is reported only while the line rests in the gap
  a_r8_strobe_in_gap: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> idle);

endmodule

// File: tb/kp_poll_ctrl_test.sv
`timescale 1ns/1ps
module kp_poll_ctrl_test;

  localparam int LO = 2, HI = 3, SP = 4, GAP = 40, NP = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in;
  logic       line_drv_lo, line_drv_hi, key_valid, idle;
  logic [3:0] key_code;

  always #10 clk = ~clk;

  kp_poll_ctrl #(
    .LO_CYC(LO), .HI_CYC(HI), .SAMP_CYC(SP), .GAP_CYC(GAP), .PULSES(NP)
  ) uut (
    .clk(clk), .rst(rst), .line_in(line_in),
    .line_drv_lo(line_drv_lo), .line_drv_hi(line_drv_hi),
    .key_valid(key_valid), .key_code(key_code), .idle(idle)
  );

  // remote keypad model: steps on each assertion of the drive-low enable
  logic [15:0] keys = 16'h0;
  int          offs = 0;
  int          rpos;
  logic        rprev;
  int          epos;

  always @(posedge clk) begin
    if (rst) begin
      rpos  <= 25;
      rprev <= 1'b1;
    end else begin
      rprev <= line_drv_lo;
      if (line_drv_lo && !rprev) rpos <= (rpos == 29) ? 0 : rpos + 1;
    end
  end

  assign epos = (rpos + offs) % 30;

  function automatic logic pull(input int p, input logic [15:0] k);
    logic r;
    r = 1'b0;
    if (p >= 25) r = 1'b1;
    else if (p < 20) begin
      for (int cc = 1; cc <= 4; cc++)
        if (k[(p / 5) * 4 + cc - 1] && cc != (p % 5)) r = 1'b1;
    end
    return r;
  endfunction

  assign line_in = line_drv_lo ? 1'b0 : (line_drv_hi ? 1'b1 : !pull(epos, keys));

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  logic [4:0] exp_q[$];
  string      req_q[$];
  logic [3:0] last_code = 4'd0;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // monitor
  int kv_cnt = 0, kv_cyc = 0, hi_rises = 0, hi_cyc = 0, gap_len = 0, pend = 0;
  int excl_bad = 0;
  bit idle_p = 1'b1, hi_p = 1'b0, seen = 1'b0;
  logic [4:0] item;
  string      rq;

  always @(negedge clk) begin
    if (!rst) begin
      if (line_drv_lo && line_drv_hi) excl_bad++;
      if (key_valid) kv_cyc++;
      if (key_valid && !(kv_cyc > 1)) kv_cnt++;
      if (line_drv_hi && !hi_p) hi_rises++;
      if (line_drv_hi) hi_cyc++;
      if (idle && !idle_p) begin
        gap_len = 1;
        pend    = 8;
        kv_cyc  = 0;
      end else if (idle) gap_len++;
      if (!idle && idle_p) begin
        if (seen) check("R2", "gap length", gap_len, GAP);
        seen = 1'b1;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          if (exp_q.size() == 0) check("R8", "unexpected burst", 1, 0);
          else begin
            item = exp_q.pop_front();
            rq   = req_q.pop_front();
            check(rq, "strobe count", kv_cnt, int'(item[4]));
            if (item[4]) check(rq, "strobe width", kv_cyc, 1);
            check(rq, "key code", int'(key_code), int'(item[3:0]));
          end
          check("R4", "pulses per burst", hi_rises, NP);
          check("R3", "drive-high cycles", hi_cyc, NP * HI);
          kv_cnt = 0; kv_cyc = 0; hi_rises = 0; hi_cyc = 0;
        end
      end
      idle_p = idle;
      hi_p   = line_drv_hi;
    end
  end

  task automatic wait_burst_end();
    @(negedge clk);
    while (idle !== 1'b0) @(negedge clk);
    while (idle !== 1'b1) @(negedge clk);
  endtask

  task automatic burst(input logic [15:0] k, input bit v, input int code, input string req);
    keys = k;
    if (v) last_code = 4'(code);
    exp_q.push_back({v, last_code});
    req_q.push_back(req);
    wait_burst_end();
  endtask

  function automatic logic [15:0] km(input int code);
    return 16'h1 << code;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "idle in reset", int'(idle), 1);
    check("R1", "drive low in reset", int'(line_drv_lo), 1);
    check("R1", "drive high in reset", int'(line_drv_hi), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "key_valid after reset", int'(key_valid), 0);
    check("R1", "key_code after reset", int'(key_code), 0);
    check("R1", "idle after reset", int'(idle), 1);

    burst(16'h0,           1'b0, 0,  "R9 no key, R5 first marker");
    burst(km(0),           1'b1, 0,  "R8 key 1");
    burst(km(15),          1'b1, 15, "R8 key D");
    burst(km(5),           1'b1, 5,  "R6 key 5");
    burst(km(14),          1'b1, 14, "R7 key #");
    burst(km(0) | km(1),   1'b0, 0,  "R6 two keys in one row");
    burst(km(1) | km(9),   1'b0, 0,  "R7 two key rows");
    burst(km(10),          1'b1, 10, "R8 key 9");
    // key changes between the two scans of a burst
    keys = km(2);
    last_code = last_code;
    exp_q.push_back({1'b0, last_code});
    req_q.push_back("R9 scans disagree");
    @(negedge clk);
    while (!(epos == 22 && idle == 1'b0)) @(negedge clk);
    keys = km(6);
    wait_burst_end();
    // phase jump of the remote scan
    offs = (offs + 20) % 30;
    burst(km(13),          1'b0, 0,  "R10 one scan after realign, R5");
    burst(km(13),          1'b1, 13, "R10 straddling scan, key 0");
    burst(km(3),           1'b0, 0,  "R10 mixed straddling scan");
    burst(km(3),           1'b1, 3,  "R8 key A after realign");

    repeat (12) @(negedge clk);
    check("R3", "overlapping enables", excl_bad, 0);
    check("R8", "pending expectations", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule